// File: doc/BRIEF.md
# TDM Receive Slot Mask Gate

This block is the front end of a time-division-multiplexed serial receiver. A frame sync marks the first bit of slot 0. After that, the block shifts serial data into a shift register one bit per bit-clock tick, most significant bit first, for a configurable number of slots. At the last bit of each slot, a 32-bit slot mask decides what happens to the shifted word. If the slot's bit is set, the word moves into a receive data register and a receive-full flag is raised. If the bit is clear, the word is dropped and no flag moves.

Software programs the mask as two 16-bit halves through a small register port. It drains words by reading the data register. A mask write goes into a pending copy. The pending copy becomes active only at the next frame sync, so a frame already in progress is gated by the mask it started with. Both copies come out of reset as all ones. Reset can be the asynchronous hardware reset or a synchronous soft reset input.

Top module: `tdm_rx_slot_gate`

## Requirements
- R1: Register address 1 holds mask bits for slots 0..15 and address 2 holds slots 16..31, each in data bits 15:0. Address 0 reads the received word, zero-extended to 24 bits.
- R2: Bits 23:16 of both mask registers always read as zero, whatever was written to them.
- R3: A frame starts on a bit tick with frame sync high. That tick carries bit 0 (the MSB) of slot 0. Each slot is SLOT_W ticks long, and mask bit N gates slot N.
- R4: When a slot ends with its mask bit clear, the data register keeps its previous word, and neither the full flag nor the overrun flag is set.
- R5: When a slot ends with its mask bit set, the data register takes that slot's word and the full flag is high from the next clock.
- R6: A mask write made during a frame does not change which slots of that frame are captured. It takes effect from the next frame sync.
- R7: Reading a mask register returns the value last written to it, even before that value becomes active.
- R8: After the hardware reset or a soft reset, both mask registers read 0xFFFF, all slots are enabled, and both flags are low.
- R9: An enabled slot that ends while the full flag is still set raises the overrun flag.
- R10: A read of address 0 clears both the full flag and the overrun flag, unless an enabled slot ends in the same cycle.
- R11: Slots with an index at or beyond the programmed slot count are never captured. Ticks that arrive after the last slot and before the next frame sync have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| fsync | input | 1 | Frame sync, sampled with bit_tick |
| sdata | input | 1 | Serial data, sampled with bit_tick |
| slot_count | input | 6 | Slots per frame (1..32) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data |
| rx_full | output | 1 | Receive-full flag |
| rx_ovr | output | 1 | Overrun flag |

## Verification
The bench changes the mask in the middle of a frame. A design that loaded the active mask on every write would capture the wrong slots for the rest of that frame. It also reads the mask back straight after the write, which catches a readback wired to the active copy instead of the pending one. Frames with no reads in between aim at overrun: a design that tested the flag after setting it, or that let masked slots touch the flags, would raise overrun at the wrong slot. The bench also sends extra ticks after the last slot, and uses mask patterns that reach slots 16 and 31, to catch a counter that wraps or a half-register decoded to the wrong slots.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int REG_W   = 24;
  localparam int HALF_W  = 16;
  localparam int NSLOT   = 32;
  localparam int SLOT_IW = $clog2(NSLOT);

  localparam logic [1:0] ADDR_DATA    = 2'd0;
  localparam logic [1:0] ADDR_MASK_LO = 2'd1;
  localparam logic [1:0] ADDR_MASK_HI = 2'd2;
endpackage

// File: rtl/tdm_rx_slot_timer.sv
module tdm_rx_slot_timer
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               tick,
  input  logic               fsync,
  input  logic [SLOT_IW:0]   slot_count,
  output logic               run,
  output logic [SLOT_IW-1:0] slot_idx,
  output logic               slot_end,
  output logic               shift_en
);
  localparam int BW = $clog2(SLOT_W);

  logic               run_q, run_d;
  logic [SLOT_IW-1:0] slot_q, slot_d;
  logic [BW-1:0]      bit_q, bit_d;
  logic               last_bit, last_slot;

  assign last_bit  = (bit_q == BW'(SLOT_W - 1));
  assign last_slot = (({1'b0, slot_q} + 1'b1) >= slot_count) || (&slot_q);

  always_comb begin
    run_d  = run_q;
    slot_d = slot_q;
    bit_d  = bit_q;
    if (soft_rst) begin
      run_d  = 1'b0;
      slot_d = '0;
      bit_d  = '0;
    end else if (tick && fsync) begin
      run_d  = 1'b1;
      slot_d = '0;
      bit_d  = BW'(1);
    end else if (tick && run_q) begin
      if (last_bit) begin
        bit_d = '0;
        if (last_slot) run_d  = 1'b0;
        else           slot_d = slot_q + 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
    end else begin
      run_q  <= run_d;
      slot_q <= slot_d;
      bit_q  <= bit_d;
    end
  end

  assign run      = run_q;
  assign slot_idx = slot_q;
  assign slot_end = tick && run_q && !fsync && !soft_rst && last_bit;
  assign shift_en = tick && (fsync || run_q);
endmodule

// File: rtl/tdm_rx_mask_bank.sv
module tdm_rx_mask_bank
  import tdm_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               frame_load,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [HALF_W-1:0]  wr_half,
  input  logic [SLOT_IW-1:0] slot_idx,
  output logic               slot_en,
  output logic [NSLOT-1:0]   shadow,
  output logic [NSLOT-1:0]   active
);
  logic [NSLOT-1:0] shadow_q, shadow_d;
  logic [NSLOT-1:0] active_q, active_d;

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [1:0] HADDR = (h == 0) ? ADDR_MASK_LO : ADDR_MASK_HI;
    always_comb begin
      shadow_d[h*HALF_W +: HALF_W] = shadow_q[h*HALF_W +: HALF_W];
      if (soft_rst)
        shadow_d[h*HALF_W +: HALF_W] = '1;
      else if (reg_wr && reg_addr == HADDR)
        shadow_d[h*HALF_W +: HALF_W] = wr_half;
    end
  end

  always_comb begin
    active_d = active_q;
    if (soft_rst)        active_d = '1;
    else if (frame_load) active_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '1;
      active_q <= '1;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  assign slot_en = active_q[slot_idx];
  assign shadow  = shadow_q;
  assign active  = active_q;
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              shift_en,
  input  logic              sdata,
  input  logic              slot_end,
  input  logic              slot_en,
  input  logic              rd_data,
  output logic [SLOT_W-1:0] rx_word,
  output logic              rx_full,
  output logic              rx_ovr
);
  logic [SLOT_W-1:0] sh_q, sh_d, word_q, word_d;
  logic              full_q, full_d, ovr_q, ovr_d;
  logic              take;

  assign take = slot_end && slot_en;

  always_comb begin
    sh_d   = sh_q;
    word_d = word_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    if (shift_en) sh_d = {sh_q[SLOT_W-2:0], sdata};
    if (soft_rst) begin
      sh_d   = '0;
      word_d = '0;
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end else if (take) begin
      word_d = {sh_q[SLOT_W-2:0], sdata};
      full_d = 1'b1;
      ovr_d  = full_q || (ovr_q && !rd_data);
    end else if (rd_data) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      word_q <= word_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rx_word = word_q;
  assign rx_full = full_q;
  assign rx_ovr  = ovr_q;
endmodule

// File: rtl/tdm_rx_slot_gate.sv
module tdm_rx_slot_gate
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             bit_tick,
  input  logic             fsync,
  input  logic             sdata,
  input  logic [5:0]       slot_count,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [23:0]      reg_wdata,
  output logic [23:0]      reg_rdata,
  output logic             rx_full,
  output logic             rx_ovr
);
  logic [1:0]         rst_sync_q;
  logic               rst_ns;
  logic               run, slot_end, shift_en, slot_en, rd_data;
  logic [SLOT_IW-1:0] slot_idx;
  logic [NSLOT-1:0]   shadow, active;
  logic [SLOT_W-1:0]  rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns  = rst_sync_q[1];
  assign rd_data = reg_rd && (reg_addr == ADDR_DATA);

  tdm_rx_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst_n(rst_ns), .soft_rst(soft_rst), .tick(bit_tick),
    .fsync(fsync), .slot_count(slot_count), .run(run), .slot_idx(slot_idx),
    .slot_end(slot_end), .shift_en(shift_en)
  );

  tdm_rx_mask_bank u_mask (
    .clk(clk), .rst_n(rst_ns), .soft_rst(soft_rst),
    .frame_load(bit_tick && fsync), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wr_half(reg_wdata[HALF_W-1:0]), .slot_idx(slot_idx), .slot_en(slot_en),
    .shadow(shadow), .active(active)
  );

  tdm_rx_capture #(.SLOT_W(SLOT_W)) u_cap (
    .clk(clk), .rst_n(rst_ns), .soft_rst(soft_rst), .shift_en(shift_en),
    .sdata(sdata), .slot_end(slot_end), .slot_en(slot_en), .rd_data(rd_data),
    .rx_word(rx_word), .rx_full(rx_full), .rx_ovr(rx_ovr)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_DATA:    reg_rdata = REG_W'(rx_word);
      ADDR_MASK_LO: reg_rdata = {8'h00, shadow[HALF_W-1:0]};
      ADDR_MASK_HI: reg_rdata = {8'h00, shadow[NSLOT-1:HALF_W]};
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tdm_rx_slot_gate_chk.sv
module tdm_rx_slot_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        bit_tick,
  input logic        fsync,
  input logic        slot_end,
  input logic        slot_en,
  input logic        rd_data,
  input logic        reg_rd,
  input logic [1:0]  reg_addr,
  input logic [23:0] reg_rdata,
  input logic        rx_full,
  input logic        rx_ovr,
  input logic [31:0] shadow,
  input logic [31:0] active
);
  always_comb begin
    if (rst_n && reg_rd && reg_addr != 2'd0)
      p_reserved_zero_r2: assert (reg_rdata[23:16] == 8'h00);
  end

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end && !slot_en && !rd_data && !soft_rst |=> $stable(rx_full) && $stable(rx_ovr));

  p_enabled_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end && slot_en && !soft_rst |=> rx_full);

  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_tick && fsync) && !soft_rst |=> $stable(active));

  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (&shadow) && (&active) && !rx_full && !rx_ovr);

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end && slot_en && rx_full && !soft_rst |=> rx_ovr);

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !(slot_end && slot_en) |=> !rx_full && !rx_ovr);
endmodule

bind tdm_rx_slot_gate tdm_rx_slot_gate_chk u_chk (
  .clk(clk), .rst_n(rst_ns), .soft_rst(soft_rst), .bit_tick(bit_tick),
  .fsync(fsync), .slot_end(slot_end), .slot_en(slot_en), .rd_data(rd_data),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .rx_full(rx_full), .rx_ovr(rx_ovr), .shadow(shadow), .active(active)
);

// File: tb/tdm_rx_slot_gate_test.sv
module tdm_rx_slot_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int WATCHDOG_CYC = 150000;

  // {mask_lo, mask_hi, slots, base, expected captured count}
  localparam logic [53:0] VEC [6] = '{
    {16'hFFFF, 16'hFFFF, 6'd8,  8'h10, 8'd8},
    {16'h0005, 16'h0000, 6'd8,  8'h20, 8'd2},
    {16'h0000, 16'h8001, 6'd32, 8'h40, 8'd2},
    {16'hAAAA, 16'h5555, 6'd32, 8'h60, 8'd16},
    {16'h00F0, 16'h0000, 6'd6,  8'h80, 8'd2},
    {16'h0001, 16'h0000, 6'd1,  8'h90, 8'd1}
  };

  logic clk, rst_n, soft_rst, bit_tick, fsync, sdata, reg_wr, reg_rd;
  logic [5:0]  slot_count;
  logic [1:0]  reg_addr;
  logic [23:0] reg_wdata, reg_rdata;
  logic        rx_full, rx_ovr;

  int n_checks = 0, n_fail = 0;
  logic [31:0] pend_mask;
  logic        exp_full, exp_ovr;
  logic [23:0] exp_data;

  tdm_rx_slot_gate #(.SLOT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bit_tick(bit_tick),
    .fsync(fsync), .sdata(sdata), .slot_count(slot_count), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_full(rx_full), .rx_ovr(rx_ovr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick_bit(input logic fs, input logic d);
    @(negedge clk);
    bit_tick = 1'b1; fsync = fs; sdata = d;
    @(negedge clk);
    bit_tick = 1'b0; fsync = 1'b0; sdata = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd1) pend_mask[15:0]  = d[15:0];
    if (a == 2'd2) pend_mask[31:16] = d[15:0];
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [23:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    if (a == 2'd0) begin exp_full = 1'b0; exp_ovr = 1'b0; end
  endtask

  task automatic send_frame(input int n, input int base, input bit do_read,
                            input int wr_slot, input logic [15:0] wlo,
                            input logic [15:0] whi, output int en_cnt);
    logic [31:0] act;
    logic [W-1:0] word;
    logic [23:0] rd;
    act = pend_mask;
    en_cnt = 0;
    slot_count = 6'(n);
    for (int s = 0; s < n; s++) begin
      word = W'(base + s);
      for (int b = 0; b < W; b++) tick_bit(s == 0 && b == 0, word[W-1-b]);
      if (act[s]) begin
        if (exp_full) exp_ovr = 1'b1;
        exp_full = 1'b1;
        exp_data = 24'(word);
        en_cnt++;
        chk("R5 full after enabled slot", 32'(rx_full), 32'(exp_full));
        chk("R9 overrun state", 32'(rx_ovr), 32'(exp_ovr));
      end else begin
        chk("R4 masked slot full", 32'(rx_full), 32'(exp_full));
        chk("R4 masked slot overrun", 32'(rx_ovr), 32'(exp_ovr));
      end
      if (do_read) begin
        reg_read(2'd0, rd);
        chk(act[s] ? "R5 data word" : "R4 data retained", 32'(rd), 32'(exp_data));
        chk("R10 full cleared by read", 32'(rx_full), 32'd0);
      end
      if (s == wr_slot) begin
        reg_write(2'd1, {8'h00, wlo});
        reg_write(2'd2, {8'h00, whi});
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] rd;
    int cnt;
    rst_n = 1'b0; soft_rst = 1'b0; bit_tick = 1'b0; fsync = 1'b0; sdata = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = '0; slot_count = 6'd8;
    pend_mask = '1; exp_full = 1'b0; exp_ovr = 1'b0; exp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state
    chk("R8 full at reset", 32'(rx_full), 32'd0);
    chk("R8 overrun at reset", 32'(rx_ovr), 32'd0);
    reg_read(2'd1, rd); chk("R8 mask low at reset", 32'(rd), 32'h00FFFF);
    reg_read(2'd2, rd); chk("R8 mask high at reset", 32'(rd), 32'h00FFFF);

    // R1 R3 R4 R5: vector table
    foreach (VEC[i]) begin
      reg_write(2'd1, {8'h00, VEC[i][53:38]});
      reg_write(2'd2, {8'h00, VEC[i][37:22]});
      send_frame(int'(VEC[i][21:16]), int'(VEC[i][15:8]), 1'b1, -1, '0, '0, cnt);
      chk("R3 captured slot count", 32'(cnt), 32'(VEC[i][7:0]));
    end

    // R2 reserved bits and R1 mapping
    reg_write(2'd1, 24'hFF1234);
    reg_read(2'd1, rd); chk("R2 reserved low reads zero", 32'(rd), 32'h001234);
    reg_write(2'd2, 24'hA5BEEF);
    reg_read(2'd2, rd); chk("R2 reserved high reads zero", 32'(rd), 32'h00BEEF);

    // R6 R7 mid-frame mask change
    reg_write(2'd1, 24'h00FFFF);
    reg_write(2'd2, 24'h00FFFF);
    send_frame(4, 8'hB0, 1'b1, 1, 16'h0001, 16'h0000, cnt);
    chk("R6 frame keeps starting mask", 32'(cnt), 32'd4);
    reg_read(2'd1, rd); chk("R7 readback of written mask", 32'(rd), 32'h000001);
    send_frame(4, 8'hC0, 1'b1, -1, '0, '0, cnt);
    chk("R6 new mask from next frame", 32'(cnt), 32'd1);

    // R9 R10 overrun without reads
    reg_write(2'd1, 24'h00FFFF);
    send_frame(3, 8'hD0, 1'b0, -1, '0, '0, cnt);
    chk("R9 overrun raised", 32'(rx_ovr), 32'd1);
    reg_read(2'd0, rd);
    chk("R9 last word kept", 32'(rd), 32'h0000D2);
    chk("R10 overrun cleared by read", 32'(rx_ovr), 32'd0);
    chk("R10 full cleared by read", 32'(rx_full), 32'd0);

    // R11 ticks beyond slot count
    send_frame(2, 8'hE0, 1'b1, -1, '0, '0, cnt);
    for (int b = 0; b < 2*W; b++) tick_bit(1'b0, 1'b1);
    chk("R11 no capture past slot count", 32'(rx_full), 32'd0);
    reg_read(2'd0, rd); chk("R11 data unchanged", 32'(rd), 32'h0000E1);

    // R8 soft reset
    reg_write(2'd1, 24'h000000);
    reg_write(2'd2, 24'h000000);
    send_frame(2, 8'hF0, 1'b0, -1, '0, '0, cnt);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    pend_mask = '1;
    reg_read(2'd1, rd); chk("R8 soft reset mask low", 32'(rd), 32'h00FFFF);
    reg_read(2'd2, rd); chk("R8 soft reset mask high", 32'(rd), 32'h00FFFF);
    send_frame(3, 8'h30, 1'b1, -1, '0, '0, cnt);
    chk("R8 all slots enabled after soft reset", 32'(cnt), 32'd3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule